// File: doc/BRIEF.md
# Mono PCM Byte Stream to I2S Player

This block plays uncompressed mono audio that arrives one byte at a time, such as a byte reader on a serial flash would deliver, and sends it out as a continuous stereo I2S stream. Each pair of incoming bytes becomes one signed 16-bit sample. Samples go into one half of a two-half sample store. The other half, once it is full, is read out one sample per I2S frame. The samples go in the left slot and the right slot always carries zero, so an amplifier set to one channel reproduces the clip.

The store decouples a bursty refill from the fixed playout rate. The fill side stalls the upstream reader while both halves hold unplayed audio. The drain side moves to the other half only when it has finished the current one. If the next half is not ready, silence is sent and a sticky underrun flag is raised. A start pulse empties the store and begins filling half 0. A stop pulse lets the frame in progress complete and then keeps the data line low. The block generates the bit clock and word select itself, from a divided system clock.

Top module: `pcm_i2s_streamer`

## Requirements
- R1: The first accepted byte of each pair is the low byte and the second is the high byte of a 16-bit sample, so bytes 0x34 then 0x12 play as 0x1234.
- R2: Each frame has a left slot, with word select low, holding the sample, and a right slot, with word select high, holding zero. Each slot is sent MSB first, with its MSB on the first bit-clock rising edge after the word-select change. The slot's LSB falls on the rising edge where word select changes again.
- R3: Samples play in the order they were accepted, one per frame, with no silent frame between store halves while the next half is already full.
- R4: The ready output is low whenever both halves hold unplayed samples. No accepted sample is lost or overwritten.
- R5: After playback has begun, a frame whose half is not ready sends a zero sample and sets the underrun output. Underrun stays set until the next start pulse. While the first half is still filling after a start, zero frames are sent without setting underrun.
- R6: After a stop pulse, ready goes low. The frame in progress completes, and from the next frame on the data line stays low.
- R7: A start pulse empties both halves, drops a pending unpaired byte and clears underrun. Filling then begins at half 0, so the first sample played after a start is the first pair accepted after it.
- R8: During reset the bit clock, word select, data, ready and underrun outputs are all low.
- R9: The bit clock period is 2*BCLK_HALF system clocks, and a frame is 32 bit clocks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle pulse: empty the store and begin playback |
| stopReq | input | 1 | One-cycle pulse: end playback after the current frame |
| inData | input | 8 | Audio byte |
| inValid | input | 1 | inData holds a byte |
| inReady | output | 1 | Block accepts the byte this cycle |
| i2sBclk | output | 1 | I2S bit clock |
| i2sWs | output | 1 | I2S word select, low for the data slot |
| i2sSd | output | 1 | I2S serial data |
| underrun | output | 1 | Sticky: playout ran ahead of the fill |

## Verification
The bench decodes the serial line on bit-clock rising edges and compares the left words with byte pairs it has built itself. A byte-order swap, a one-bit slot shift or nonzero right slots each show up as wrong words. It fills more than two halves in a row, so that ready must drop and refill must resume. A design that let the fill side overwrite a half, or skip a half, would corrupt or reorder the sequence. It drains the store dry and then refills it, to check that silence is sent, that underrun stays set after audio resumes, and that no underrun is flagged while the store primes after a start. Stop is issued mid-playback, and a restart follows a stranded odd byte. A design that kept old samples or the odd byte after start would play a wrong first word.

// File: rtl/pcm_i2s_pkg.sv
package pcm_i2s_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic lowLatch;   // hold the incoming byte as the low half of a sample
    logic wrEn;       // write {inData, low byte} to the store
    logic bitTick;    // bit clock falls this cycle: advance the serial bit
    logic frameStart; // new frame: load the next left-slot sample
    logic loadData;   // with frameStart: 1 = take stored sample, 0 = silence
  } strobe_t;
endpackage

// File: rtl/pcm_i2s_ctrl.sv
module pcm_i2s_ctrl
  import pcm_i2s_pkg::*;
#(
  parameter int N         = 256,
  parameter int BCLK_HALF = 2,
  parameter int SLOT_W    = 16,
  localparam int AW = (N > 1) ? $clog2(N) : 1,
  localparam int BW = $clog2(2 * SLOT_W),
  localparam int DW = $clog2(BCLK_HALF) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          stopReq,
  input  logic          inValid,
  output logic          inReady,
  output logic          underrun,
  output logic          i2sBclk,
  output logic          i2sWs,
  output strobe_t       stb,
  output logic          wrHalf,
  output logic [AW-1:0] wrIdx,
  output logic          rdHalf,
  output logic [AW-1:0] rdIdx,
  output logic [BW-1:0] bitIdx
);
  logic [DW-1:0] divCnt;
  logic          bclkReg;
  logic          wsReg;
  logic [BW-1:0] nextIdx;
  logic          halfTick;
  logic          fallTick;
  logic          frameStart;
  logic [1:0]    full;
  logic          playing;
  logic          haveLow;
  logic          started;
  logic          underrunReg;
  logic          accept;
  logic          drainGo;
  logic          takeSample;

  // ---------------- bit clock and frame timing ----------------
  assign halfTick   = (divCnt == DW'(BCLK_HALF - 1));
  assign fallTick   = halfTick && bclkReg;
  assign nextIdx    = bitIdx + BW'(1);
  assign frameStart = fallTick && (bitIdx == BW'(2 * SLOT_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      bclkReg <= 1'b0;
      wsReg   <= 1'b0;
      bitIdx  <= '1;
    end else begin
      if (halfTick) begin
        divCnt  <= '0;
        bclkReg <= ~bclkReg;
      end else begin
        divCnt <= divCnt + DW'(1);
      end
      if (fallTick) begin
        bitIdx <= nextIdx;
        wsReg  <= (nextIdx >= BW'(SLOT_W));
      end
    end
  end

  // ---------------- fill and drain bookkeeping ----------------
  assign inReady    = playing && !full[wrHalf];
  assign accept     = inValid && inReady;
  assign drainGo    = frameStart && playing && !stopReq && !startReq;
  assign takeSample = drainGo && full[rdHalf];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full        <= '0;
      playing     <= 1'b0;
      haveLow     <= 1'b0;
      started     <= 1'b0;
      underrunReg <= 1'b0;
      wrHalf      <= 1'b0;
      wrIdx       <= '0;
      rdHalf      <= 1'b0;
      rdIdx       <= '0;
    end else if (startReq) begin
      full        <= '0;
      playing     <= 1'b1;
      haveLow     <= 1'b0;
      started     <= 1'b0;
      underrunReg <= 1'b0;
      wrHalf      <= 1'b0;
      wrIdx       <= '0;
      rdHalf      <= 1'b0;
      rdIdx       <= '0;
    end else begin
      if (stopReq) playing <= 1'b0;
      if (accept) begin
        if (!haveLow) begin
          haveLow <= 1'b1;
        end else begin
          haveLow <= 1'b0;
          if (wrIdx == AW'(N - 1)) begin
            full[wrHalf] <= 1'b1;
            wrHalf       <= ~wrHalf;
            wrIdx        <= '0;
          end else begin
            wrIdx <= wrIdx + AW'(1);
          end
        end
      end
      if (takeSample) begin
        started <= 1'b1;
        if (rdIdx == AW'(N - 1)) begin
          full[rdHalf] <= 1'b0;
          rdHalf       <= ~rdHalf;
          rdIdx        <= '0;
        end else begin
          rdIdx <= rdIdx + AW'(1);
        end
      end else if (drainGo && started) begin
        underrunReg <= 1'b1;
      end
    end
  end

  always_comb begin
    stb            = '0;
    stb.lowLatch   = accept && !haveLow;
    stb.wrEn       = accept && haveLow;
    stb.bitTick    = fallTick;
    stb.frameStart = frameStart;
    stb.loadData   = takeSample;
  end

  assign i2sBclk  = bclkReg;
  assign i2sWs    = wsReg;
  assign underrun = underrunReg;

  // R4
  ready_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full == 2'b11) |-> !inReady);

  // R3
  half_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeSample && rdIdx == AW'(N - 1)) |=> (rdHalf != $past(rdHalf)));

  // R5
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !startReq) |=> underrun);

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (full == 2'b00 && !underrun && !wrHalf && !haveLow));
endmodule

// File: rtl/pcm_i2s_datapath.sv
module pcm_i2s_datapath
  import pcm_i2s_pkg::*;
#(
  parameter int N      = 256,
  parameter int BYTE_W = 8,
  localparam int SLOT_W = 2 * BYTE_W,
  localparam int AW = (N > 1) ? $clog2(N) : 1,
  localparam int BW = $clog2(2 * SLOT_W),
  localparam int SW = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] inData,
  input  logic              wrHalf,
  input  logic [AW-1:0]     wrIdx,
  input  logic              rdHalf,
  input  logic [AW-1:0]     rdIdx,
  input  logic [BW-1:0]     bitIdx,
  input  logic              i2sWs,
  output logic              i2sSd
);
  logic [BYTE_W-1:0] lowByte;
  logic [SLOT_W-1:0] curSample;
  logic [SLOT_W-1:0] bankRd [2];
  logic [SLOT_W-1:0] rdData;
  logic [BW-1:0]     nextIdx;
  logic [BW-1:0]     selIdx;
  logic              inSlot;
  logic              sdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowByte <= '0;
    else if (stb.lowLatch) lowByte <= inData;
  end

  // One storage bank per half of the ping-pong pair
  for (genvar h = 0; h < 2; h++) begin : g_bank
    logic [SLOT_W-1:0] mem [N];
    always_ff @(posedge clk) begin
      if (stb.wrEn && (wrHalf == 1'(h))) mem[wrIdx] <= {inData, lowByte};
    end
    assign bankRd[h] = mem[rdIdx];
  end

  assign rdData = rdHalf ? bankRd[1] : bankRd[0];

  // Left slot carries bits SLOT_W-1..0 on frame bits 1..SLOT_W (one-bit delay)
  assign nextIdx = bitIdx + BW'(1);
  assign selIdx  = BW'(SLOT_W) - nextIdx;
  assign inSlot  = (nextIdx >= BW'(1)) && (nextIdx <= BW'(SLOT_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSample <= '0;
      sdReg     <= 1'b0;
    end else begin
      if (stb.frameStart) curSample <= stb.loadData ? rdData : '0;
      if (stb.bitTick) sdReg <= inSlot ? curSample[selIdx[SW-1:0]] : 1'b0;
    end
  end

  assign i2sSd = sdReg;

  // R2
  right_slot_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (i2sWs && bitIdx != BW'(SLOT_W)) |-> !i2sSd);

  // R5
  silent_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.frameStart && !stb.loadData) |=> (curSample == '0));
endmodule

// File: rtl/pcm_i2s_streamer.sv
module pcm_i2s_streamer #(
  parameter int N         = 256,
  parameter int BCLK_HALF = 2,
  parameter int BYTE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              i2sBclk,
  output logic              i2sWs,
  output logic              i2sSd,
  output logic              underrun
);
  localparam int SLOT_W = 2 * BYTE_W;
  localparam int AW = (N > 1) ? $clog2(N) : 1;
  localparam int BW = $clog2(2 * SLOT_W);

  pcm_i2s_pkg::strobe_t stb;
  logic          wrHalf;
  logic [AW-1:0] wrIdx;
  logic          rdHalf;
  logic [AW-1:0] rdIdx;
  logic [BW-1:0] bitIdx;

  pcm_i2s_ctrl #(.N(N), .BCLK_HALF(BCLK_HALF), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .inValid(inValid), .inReady(inReady), .underrun(underrun),
    .i2sBclk(i2sBclk), .i2sWs(i2sWs), .stb(stb),
    .wrHalf(wrHalf), .wrIdx(wrIdx), .rdHalf(rdHalf), .rdIdx(rdIdx),
    .bitIdx(bitIdx)
  );

  pcm_i2s_datapath #(.N(N), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .wrHalf(wrHalf), .wrIdx(wrIdx), .rdHalf(rdHalf), .rdIdx(rdIdx),
    .bitIdx(bitIdx), .i2sWs(i2sWs), .i2sSd(i2sSd)
  );
endmodule

// File: tb/pcm_i2s_streamer_bench.sv
`timescale 1ns/1ps
module pcm_i2s_streamer_bench;
  localparam int NS = 4;          // samples per half in the bench
  localparam int FRAME = 128;     // system clocks per frame (32 bits x 4)

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       stopReq = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady, i2sBclk, i2sWs, i2sSd, underrun;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pcm_i2s_streamer #(.N(NS), .BCLK_HALF(2), .BYTE_W(8)) u_pcm_i2s_streamer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .i2sBclk(i2sBclk), .i2sWs(i2sWs), .i2sSd(i2sSd), .underrun(underrun)
  );

  // ---------------- I2S receiver model ----------------
  logic [15:0] leftLog [4096];
  int          leftCnt = 0;
  int          rightBad = 0;
  int          sdHigh = 0;
  int          bclkPeriod = 0;
  int          sinceRise = 0;
  int          bitsInFrame = 0;
  int          lastFrameBits = 0;
  logic        prevBclk = 1'b0;
  logic        prevWs = 1'b0;
  logic [15:0] sh = '0;

  always @(negedge clk) begin
    sinceRise++;
    if (i2sBclk && !prevBclk) begin
      bclkPeriod = sinceRise;
      sinceRise = 0;
      sh = {sh[14:0], i2sSd};
      if (i2sSd) sdHigh++;
      if (i2sWs != prevWs) begin
        if (!prevWs) begin
          if (leftCnt < 4096) leftLog[leftCnt] = sh;
          leftCnt++;
        end else if (sh != 16'h0) begin
          rightBad++;
        end
      end
      bitsInFrame++;
      if (i2sWs && !prevWs) begin
        lastFrameBits = bitsInFrame;
        bitsInFrame = 0;
      end
      prevWs = i2sWs;
    end
    prevBclk = i2sBclk;
  end

  // ---------------- helpers ----------------
  function automatic logic [15:0] expS(input int k);
    logic [7:0] hi, lo;
    hi = 8'h90 + 8'(k);
    lo = 8'h21 + 8'(3 * k);
    return {hi, lo};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic feedByte(input logic [7:0] b);
    do @(negedge clk); while (!inReady);
    inData  = b;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic feedSample(input int k);
    logic [15:0] s;
    s = expS(k);
    feedByte(s[7:0]);
    feedByte(s[15:8]);
  endtask

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk) stopReq = 1'b1;
    @(negedge clk) stopReq = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkSeq(input int from, input int base, input int cnt, input string tag);
    int p;
    p = from;
    while (p < leftCnt && leftLog[p] == 16'h0) p++;
    for (int k = 0; k < cnt; k++) begin
      chk((p + k) < leftCnt && leftLog[p + k] == expS(base + k), tag,
          int'(leftLog[p + k]), int'(expS(base + k)));
    end
    if (p + cnt < leftCnt)
      chk(leftLog[p + cnt] == 16'h0, {tag, " silence after data"},
          int'(leftLog[p + cnt]), 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    waitCycles(3);
    // R8: all outputs low while reset is held
    chk(!i2sBclk && !i2sWs && !i2sSd, "R8 serial pins low in reset",
        {i2sBclk, i2sWs, i2sSd}, 0);
    chk(!inReady, "R8 ready low in reset", inReady, 0);
    chk(!underrun, "R8 underrun low in reset", underrun, 0);
    rstN = 1'b1;
    waitCycles(2 * FRAME);
    // R9: bit clock period and frame length
    chk(bclkPeriod == 4, "R9 bit clock period", bclkPeriod, 4);
    chk(lastFrameBits == 32, "R9 bits per frame", lastFrameBits, 32);
  endtask

  task automatic testStream();
    int from;
    pulseStart();
    chk(inReady, "R7 ready after start", inReady, 1);
    from = leftCnt;
    for (int k = 0; k < 2 * NS; k++) feedSample(k);
    // R4: both halves full, reader must stall
    chk(!inReady, "R4 ready low with both halves full", inReady, 0);
    for (int k = 2 * NS; k < 5 * NS; k++) feedSample(k);
    // R5 priming, R3 continuity: no underrun while data keeps up
    chk(!underrun, "R3 R5 no underrun while fed", underrun, 0);
    waitCycles(14 * FRAME);
    // R1 byte order, R2 slot layout, R3 order without gaps
    checkSeq(from, 0, 5 * NS, "R1 R2 R3 stream");
    chk(underrun, "R5 underrun after drain", underrun, 1);
  endtask

  task automatic testRecover();
    int from;
    from = leftCnt;
    for (int k = 5 * NS; k < 6 * NS; k++) feedSample(k);
    waitCycles(8 * FRAME);
    checkSeq(from, 5 * NS, NS, "R5 resume after underrun");
    chk(underrun, "R5 underrun sticky after resume", underrun, 1);
  endtask

  task automatic testStop();
    int mark;
    for (int k = 6 * NS; k < 7 * NS; k++) feedSample(k);
    waitCycles(2 * FRAME);
    pulseStop();
    chk(!inReady, "R6 ready low after stop", inReady, 0);
    waitCycles(FRAME + 32);
    mark = sdHigh;
    waitCycles(3 * FRAME);
    chk(sdHigh == mark, "R6 data line low after stop", sdHigh - mark, 0);
  endtask

  task automatic testRestart();
    int from;
    pulseStart();
    chk(!underrun, "R7 start clears underrun", underrun, 0);
    chk(inReady, "R7 ready after restart", inReady, 1);
    feedByte(8'hAA);
    feedByte(8'hBB);
    feedByte(8'hCC);
    pulseStart();
    from = leftCnt;
    for (int k = 7 * NS; k < 8 * NS; k++) feedSample(k);
    chk(!underrun, "R5 R7 no underrun while priming", underrun, 0);
    waitCycles(8 * FRAME);
    checkSeq(from, 7 * NS, NS, "R7 fresh fill after start");
    chk(rightBad == 0, "R2 right slot always zero", rightBad, 0);
  endtask

  initial begin
    testReset();
    testStream();
    testRecover();
    testStop();
    testRestart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule